// File: doc/BRIEF.md
# Fault-Injectable RAM Model

This block is a one-bit-wide, single-port RAM whose reads and writes can be bent to mimic the functional defects that memory self-test engines are built to catch. It sits in place of a real array in a verification or emulation build. A self-test controller can then be run against a memory with a known defect, and its pass or fail verdict compared with the fault that was injected.

A configuration port selects one fault at a time. The port carries a fault kind, a victim cell, an aggressor cell (or second address), a polarity value, a two-bit mode, and a delay in clock cycles. The supported families are cell defects (stuck value, blocked transitions), two-cell coupling (transition-triggered and state-triggered), slow charge loss, an unreachable cell, and three address-decoder defects. Read data is registered, so a read returns its bit one cycle later. The configuration is only changed while no access is being made.

Top module: `fault_ram`

## Requirements
- R1: With kind 0 (no fault) a read returns the bit last written to that address, on `rdata` in the cycle after the read is issued. Reset clears every cell and `rdata` to 0.
- R2: With kind 1 the victim cell reads as `cfg_value` whatever was written to it.
- R3: With kind 2 a write of 1 over a stored 0 at the victim is lost when `cfg_mode[0]` is 1, and a write of 0 over a stored 1 is lost when `cfg_mode[1]` is 1. A write of the value already stored behaves normally.
- R4: With kind 3 a write that changes the aggressor cell sets the victim to `cfg_value`. The change must be rising (0 to 1) when `cfg_mode[0]` is 1, or falling when it is 0. Either address may be the higher one.
- R5: With kind 4, whenever the aggressor cell holds `cfg_mode[0]`, the victim reads as `cfg_value` and writes cannot change it.
- R6: With kind 5 the victim inverts once `cfg_delay` cycles have passed since its last write. A stored 1 decays when `cfg_mode[0]` is 1, and a stored 0 decays when `cfg_mode[1]` is 1. A value whose mode bit is 0 is kept.
- R7: With kind 6 writes to the victim have no effect, and a read of the victim repeats the previous `rdata`.
- R8: With kind 7 the victim address reaches no cell: a read of it returns `cfg_value`, and a write to it changes nothing.
- R9: With kind 8 the victim address reaches both the victim cell and the aggressor cell. A write stores into both, and a read returns their AND when `cfg_mode[0]` is 0 or their OR when it is 1.
- R10: With kind 9 the aggressor address reaches the victim cell instead of its own. Reads and writes through it act on the victim cell, and the aggressor cell is left untouched.
- R11: Cells other than the victim (and, for kinds 8 and 9, the aggressor) behave as in R1 under every fault kind.
- R12: `rdata` keeps its value in any cycle in which no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Access request for this cycle |
| wr_en | input | 1 | 1 = write, 0 = read, when `acc_en` is 1 |
| addr | input | ADDR_W | Cell address |
| wdata | input | 1 | Bit to write |
| rdata | output | 1 | Registered read bit |
| cfg_kind | input | 4 | Fault kind, codes 0 to 9 as in the requirements |
| cfg_victim | input | ADDR_W | Victim cell / address |
| cfg_aggr | input | ADDR_W | Aggressor cell / second address |
| cfg_value | input | 1 | Forced or returned value |
| cfg_mode | input | 2 | Subtype bits per fault kind |
| cfg_delay | input | DELAY_W | Retention delay in cycles |

## Verification
The bench targets the points where each fault model takes effect. A write of the value already stored must not be blocked by a transition fault; a model that blocked every write would hide that later 0-to-1 write. Coupling is driven with both edge directions and with the aggressor on either side of the victim. A model that ignored the edge direction would corrupt the victim on the wrong write. Retention is read both well before and well after the delay, and with a polarity that must not decay, so that a timer that fires early or flips both values shows up as a wrong bit. The decoder faults are cross-checked by clearing the fault and reading the cells directly: this shows whether a write went to the victim, the aggressor, both, or neither. A model that answered reads correctly but stored the data in the wrong place would therefore fail.

// File: rtl/fault_ram_pkg.sv
`timescale 1ns/1ps
package fault_ram_pkg;

    typedef enum logic [3:0] {
        FK_NONE     = 4'd0,
        FK_STUCK    = 4'd1,
        FK_TRANS    = 4'd2,
        FK_CF_ID    = 4'd3,
        FK_CF_ST    = 4'd4,
        FK_RETAIN   = 4'd5,
        FK_SOPEN    = 4'd6,
        FK_AD_NONE  = 4'd7,
        FK_AD_MULTI = 4'd8,
        FK_AD_ALIAS = 4'd9
    } fault_kind_e;

endpackage

// File: rtl/fault_ram_decode.sv
`timescale 1ns/1ps
module fault_ram_decode
    import fault_ram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  fault_kind_e       kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] victim,
    input  logic [ADDR_W-1:0] aggr,
    output logic [ADDR_W-1:0] cell_a,
    output logic              a_ok,
    output logic [ADDR_W-1:0] cell_b,
    output logic              b_ok
);

    always_comb begin
        cell_a = addr;
        a_ok   = 1'b1;
        cell_b = aggr;
        b_ok   = 1'b0;
        case (kind)
            FK_AD_NONE: begin
                if (addr == victim) begin
                    a_ok = 1'b0;
                end
            end
            FK_AD_MULTI: begin
                if (addr == victim) begin
                    b_ok = 1'b1;
                end
            end
            FK_AD_ALIAS: begin
                if (addr == aggr) begin
                    cell_a = victim;
                end
            end
            default: begin
                cell_a = addr;
            end
        endcase
    end

endmodule

// File: rtl/fault_ram_retention.sv
`timescale 1ns/1ps
module fault_ram_retention #(
    parameter int DELAY_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               victim_wr,
    input  logic               victim_val,
    input  logic [1:0]         decay_mask,
    input  logic [DELAY_W-1:0] delay,
    output logic               fire
);

    typedef struct packed {
        logic [DELAY_W-1:0] cnt;
        logic               armed;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        fire  = 1'b0;
        if (!en) begin
            tmr_d.cnt   = '0;
            tmr_d.armed = 1'b0;
        end else if (victim_wr) begin
            tmr_d.cnt   = '0;
            tmr_d.armed = 1'b1;
        end else if (tmr_q.armed) begin
            if (tmr_q.cnt == delay) begin
                tmr_d.armed = 1'b0;
                fire        = victim_val ? decay_mask[0] : decay_mask[1];
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/fault_ram.sv
`timescale 1ns/1ps
module fault_ram
    import fault_ram_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DELAY_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_en,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wdata,
    output logic               rdata,
    input  logic [3:0]         cfg_kind,
    input  logic [ADDR_W-1:0]  cfg_victim,
    input  logic [ADDR_W-1:0]  cfg_aggr,
    input  logic               cfg_value,
    input  logic [1:0]         cfg_mode,
    input  logic [DELAY_W-1:0] cfg_delay
);

    localparam int CELLS = 1 << ADDR_W;

    typedef struct packed {
        logic [CELLS-1:0] mem;
        logic             rdata;
    } state_t;

    state_t st_d, st_q;

    fault_kind_e       kind;
    logic [ADDR_W-1:0] cell_a, cell_b;
    logic              a_ok, b_ok;
    logic              wr_go, rd_go;
    logic              victim_wr;
    logic              ret_fire;
    logic              old_bit, keep, sense;

    assign kind  = fault_kind_e'(cfg_kind);
    assign wr_go = acc_en & wr_en;
    assign rd_go = acc_en & ~wr_en;

    fault_ram_decode #(.ADDR_W(ADDR_W)) u_decode (
        .kind   (kind),
        .addr   (addr),
        .victim (cfg_victim),
        .aggr   (cfg_aggr),
        .cell_a (cell_a),
        .a_ok   (a_ok),
        .cell_b (cell_b),
        .b_ok   (b_ok)
    );

    assign victim_wr = wr_go & a_ok & (cell_a == cfg_victim);

    fault_ram_retention #(.DELAY_W(DELAY_W)) u_retention (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (kind == FK_RETAIN),
        .victim_wr  (victim_wr),
        .victim_val (st_q.mem[cfg_victim]),
        .decay_mask (cfg_mode),
        .delay      (cfg_delay),
        .fire       (ret_fire)
    );

    always_comb begin
        st_d    = st_q;
        old_bit = st_q.mem[cell_a];
        keep    = 1'b0;
        sense   = st_q.mem[cell_a];

        // write path
        if (wr_go) begin
            if (a_ok) begin
                if (cell_a == cfg_victim) begin
                    if (kind == FK_TRANS) begin
                        keep = (~old_bit & wdata & cfg_mode[0]) |
                               (old_bit & ~wdata & cfg_mode[1]);
                    end else if (kind == FK_SOPEN) begin
                        keep = 1'b1;
                    end
                end
                if (!keep) begin
                    st_d.mem[cell_a] = wdata;
                end
                if (kind == FK_CF_ID && cell_a == cfg_aggr &&
                    old_bit != wdata && wdata == cfg_mode[0]) begin
                    st_d.mem[cfg_victim] = cfg_value;
                end
            end
            if (b_ok) begin
                st_d.mem[cell_b] = wdata;
            end
        end

        // time and state driven corruption of the victim
        if (ret_fire) begin
            st_d.mem[cfg_victim] = ~st_q.mem[cfg_victim];
        end
        if (kind == FK_CF_ST && st_d.mem[cfg_aggr] == cfg_mode[0]) begin
            st_d.mem[cfg_victim] = cfg_value;
        end
        if (kind == FK_STUCK) begin
            st_d.mem[cfg_victim] = cfg_value;
        end

        // read path
        if (rd_go) begin
            if (!a_ok) begin
                sense = cfg_value;
            end else if (b_ok) begin
                sense = cfg_mode[0] ? (st_q.mem[cell_a] | st_q.mem[cell_b])
                                    : (st_q.mem[cell_a] & st_q.mem[cell_b]);
            end
            if (a_ok && cell_a == cfg_victim) begin
                case (kind)
                    FK_STUCK: sense = cfg_value;
                    FK_CF_ST: begin
                        if (st_q.mem[cfg_aggr] == cfg_mode[0]) begin
                            sense = cfg_value;
                        end
                    end
                    FK_SOPEN: sense = st_q.rdata;
                    default:  sense = sense;
                endcase
            end
            st_d.rdata = sense;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;

endmodule

// File: rtl/fault_ram_chk.sv
`timescale 1ns/1ps
module fault_ram_chk
    import fault_ram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              rdata,
    input logic [3:0]        cfg_kind,
    input logic [ADDR_W-1:0] cfg_victim,
    input logic              cfg_value
);

    logic rd_victim;
    assign rd_victim = acc_en && !wr_en && addr == cfg_victim;

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && !wr_en) |=> $stable(rdata));

    // R2
    stuck_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_victim && cfg_kind == FK_STUCK) |=> rdata == $past(cfg_value));

    // R7
    sopen_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_victim && cfg_kind == FK_SOPEN) |=> $stable(rdata));

    // R8
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_victim && cfg_kind == FK_AD_NONE) |=> rdata == $past(cfg_value));

endmodule

bind fault_ram fault_ram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_en     (acc_en),
    .wr_en      (wr_en),
    .addr       (addr),
    .rdata      (rdata),
    .cfg_kind   (cfg_kind),
    .cfg_victim (cfg_victim),
    .cfg_value  (cfg_value)
);

// File: tb/fault_ram_test.sv
`timescale 1ns/1ps
module fault_ram_test;

    localparam int AW = 6;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wdata = 1'b0;
    logic          rdata;
    logic [3:0]    cfg_kind = 4'd0;
    logic [AW-1:0] cfg_victim = '0;
    logic [AW-1:0] cfg_aggr = '0;
    logic          cfg_value = 1'b0;
    logic [1:0]    cfg_mode = 2'b00;
    logic [DW-1:0] cfg_delay = '0;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 1'b0;

    typedef struct {
        logic  exp;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    fault_ram #(.ADDR_W(AW), .DELAY_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .cfg_kind(cfg_kind), .cfg_victim(cfg_victim), .cfg_aggr(cfg_aggr),
        .cfg_value(cfg_value), .cfg_mode(cfg_mode), .cfg_delay(cfg_delay)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: rdata=%0b expected %0b", tag, act, exp);
        end
    endtask

    // monitor: results appear after the read's clock edge
    always @(negedge clk) begin
        if (sb.size() != 0) begin
            exp_t e;
            e = sb.pop_front();
            check(rdata, e.exp, e.tag);
        end
    end

    task automatic setcfg(input int k, input int v, input int a,
                          input logic val, input logic [1:0] m, input int d);
        @(negedge clk);
        acc_en     = 1'b0;
        cfg_kind   = 4'(k);
        cfg_victim = AW'(v);
        cfg_aggr   = AW'(a);
        cfg_value  = val;
        cfg_mode   = m;
        cfg_delay  = DW'(d);
        @(posedge clk);
    endtask

    task automatic wr(input int a, input logic d);
        @(negedge clk);
        acc_en = 1'b1;
        wr_en  = 1'b1;
        addr   = AW'(a);
        wdata  = d;
        @(posedge clk);
    endtask

    task automatic rd(input int a, input logic exp, input string tag);
        exp_t e;
        @(negedge clk);
        acc_en = 1'b1;
        wr_en  = 1'b0;
        addr   = AW'(a);
        @(posedge clk);
        e.exp = exp;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        acc_en = 1'b0;
        repeat (n) @(posedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: rdata=%0b expected completion", rdata);
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rdata, 1'b0, "R1 reset rdata");
        rd(5, 1'b0, "R1 cleared cell");

        // R1 plain storage
        wr(3, 1'b1);
        wr(4, 1'b0);
        rd(3, 1'b1, "R1 read one");
        rd(4, 1'b0, "R1 read zero");
        wr(3, 1'b0);
        rd(3, 1'b0, "R1 overwrite");

        // R12 hold without reads
        wr(10, 1'b1);
        rd(10, 1'b1, "R12 setup");
        wr(11, 1'b0);
        wr(12, 1'b0);
        idle(2);
        @(negedge clk);
        check(rdata, 1'b1, "R12 hold");

        // R2 stuck value, R11 neighbour
        setcfg(1, 20, 0, 1'b0, 2'b00, 0);
        wr(20, 1'b1);
        rd(20, 1'b0, "R2 stuck at 0");
        wr(21, 1'b1);
        rd(21, 1'b1, "R11 neighbour of stuck");
        setcfg(1, 22, 0, 1'b1, 2'b00, 0);
        rd(22, 1'b1, "R2 stuck at 1");

        // R3 transitions
        setcfg(2, 30, 0, 1'b0, 2'b01, 0);
        wr(30, 1'b1);
        rd(30, 1'b0, "R3 up blocked");
        setcfg(2, 30, 0, 1'b0, 2'b10, 0);
        wr(30, 1'b1);
        rd(30, 1'b1, "R3 up allowed");
        wr(30, 1'b0);
        rd(30, 1'b1, "R3 down blocked");
        setcfg(2, 30, 0, 1'b0, 2'b11, 0);
        wr(30, 1'b1);
        rd(30, 1'b1, "R3 same-value write");

        // R4 transition coupling
        setcfg(3, 41, 40, 1'b1, 2'b01, 0);
        wr(41, 1'b0);
        wr(40, 1'b0);
        rd(41, 1'b0, "R4 no change no effect");
        wr(40, 1'b1);
        rd(41, 1'b1, "R4 rising sets victim");
        setcfg(3, 42, 45, 1'b0, 2'b00, 0);
        wr(42, 1'b1);
        wr(45, 1'b1);
        rd(42, 1'b1, "R4 rising ignored in falling mode");
        wr(45, 1'b0);
        rd(42, 1'b0, "R4 falling clears victim");

        // R5 state coupling
        setcfg(4, 51, 50, 1'b1, 2'b01, 0);
        wr(50, 1'b0);
        wr(51, 1'b0);
        rd(51, 1'b0, "R5 inactive");
        wr(50, 1'b1);
        rd(51, 1'b1, "R5 forced");
        wr(51, 1'b0);
        rd(51, 1'b1, "R5 write while forced");
        wr(50, 1'b0);
        wr(51, 1'b0);
        rd(51, 1'b0, "R5 released");

        // R6 retention
        setcfg(5, 55, 0, 1'b0, 2'b01, 20);
        wr(55, 1'b1);
        idle(5);
        rd(55, 1'b1, "R6 before delay");
        idle(30);
        rd(55, 1'b0, "R6 decayed");
        wr(55, 1'b0);
        idle(30);
        rd(55, 1'b0, "R6 polarity kept");

        // R7 stuck-open
        setcfg(6, 60, 0, 1'b0, 2'b00, 0);
        rd(10, 1'b1, "R7 prime one");
        rd(60, 1'b1, "R7 repeats one");
        rd(4, 1'b0, "R7 prime zero");
        rd(60, 1'b0, "R7 repeats zero");
        wr(60, 1'b1);
        setcfg(0, 0, 0, 1'b0, 2'b00, 0);
        rd(60, 1'b0, "R7 write lost");

        // R8 unmapped address
        setcfg(7, 2, 0, 1'b1, 2'b00, 0);
        rd(2, 1'b1, "R8 floating value");
        setcfg(7, 2, 0, 1'b0, 2'b00, 0);
        wr(2, 1'b1);
        setcfg(0, 0, 0, 1'b0, 2'b00, 0);
        rd(2, 1'b0, "R8 write lost");

        // R9 multi-select
        setcfg(8, 6, 7, 1'b0, 2'b00, 0);
        wr(6, 1'b0);
        wr(7, 1'b1);
        rd(6, 1'b0, "R9 AND read");
        setcfg(8, 6, 7, 1'b0, 2'b01, 0);
        rd(6, 1'b1, "R9 OR read");
        wr(6, 1'b1);
        wr(7, 1'b0);
        setcfg(0, 0, 0, 1'b0, 2'b00, 0);
        rd(6, 1'b1, "R9 write reached victim");
        setcfg(8, 6, 7, 1'b0, 2'b00, 0);
        wr(6, 1'b1);
        setcfg(0, 0, 0, 1'b0, 2'b00, 0);
        rd(7, 1'b1, "R9 write reached second cell");

        // R10 alias
        setcfg(9, 8, 9, 1'b0, 2'b00, 0);
        wr(9, 1'b1);
        rd(9, 1'b1, "R10 alias read");
        setcfg(0, 0, 0, 1'b0, 2'b00, 0);
        rd(9, 1'b0, "R10 own cell untouched");
        rd(8, 1'b1, "R10 victim written");
        rd(21, 1'b1, "R11 unrelated cell");

        idle(4);
        done = 1'b1;
        summary();
    end

endmodule